// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets logic running on a single clock read and write an external byte-wide asynchronous static RAM of 128K locations. The host issues a one-cycle request carrying a write flag, a 17-bit address and a write byte. The controller answers with a one-cycle ready pulse, and on reads it presents the fetched byte alongside that pulse. On the memory side it drives active-low chip-select, output-enable and write-enable pins and an address bus. The bidirectional data bus is split into an outgoing byte, a drive-enable and an incoming byte, so that the pad ring can build the tristate buffer.

The memory's nanosecond limits are parameters, and so is the clock period. The controller rounds each limit up to whole clock cycles and uses the result to size its wait states. Between accesses it holds chip-select high, which leaves the memory in its low-power standby state. It orders the pins so that the memory and the controller never drive the data bus at the same time.

Top module: `async_sram_ctrl`

## Requirements
- R1: During reset and on the first cycle after reset, chip-select, output-enable and write-enable are high (inactive), the data drive-enable is low and ready is low. A reset during an access abandons that access.
- R2: When no access is in progress, chip-select, output-enable and write-enable are high and the data drive-enable is low. This holds on the cycle in which ready pulses.
- R3: A read drops chip-select and then output-enable, with write-enable high throughout. The byte on the incoming data bus is captured at the end of the access. The captured byte appears on the read-data output in the same cycle as the ready pulse.
- R4: Write-enable goes low only while chip-select is low and output-enable is high. The data drive-enable is high from the cycle in which write-enable falls until the cycle after write-enable rises. The byte stored is the request's write byte, at the request's address.
- R5: The data drive-enable is never high while output-enable is low. The cycle after a read, chip-select stays high and nothing is driven, which gives the memory time to release the bus.
- R6: The address and the write byte are latched when a request is accepted. The memory address stays fixed while chip-select is low, and the outgoing byte stays fixed while the drive-enable is high, whatever the host inputs do meanwhile.
- R7: Each accepted request produces exactly one ready pulse, one cycle wide. A request strobe raised while an access is in progress is ignored: it produces no memory cycle and no ready pulse.
- R8: Each timing limit becomes ceil(limit_ns / clock_period_ns) cycles, and never fewer than one. The access wait A comes from the access-time limit and the write pulse P from the write-pulse limit. Write-enable stays low for exactly P cycles. Counting the accepting clock edge as 1, ready is seen after A+3 edges for a read and after P+3 edges for a write (5 and 5 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | One-cycle request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Byte to write |
| rspReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Byte fetched by the last read |
| memCeN | output | 1 | Memory chip-select, active low |
| memOeN | output | 1 | Memory output-enable, active low |
| memWeN | output | 1 | Memory write-enable, active low |
| memAddr | output | ADDR_W | Memory address bus |
| memDout | output | DATA_W | Byte driven toward the memory |
| memDoutEn | output | 1 | Drive-enable for the data bus |
| memDin | input | DATA_W | Byte read from the data bus |

## Verification
The hardest condition to reach from the ports is a request strobe that arrives while an access is still in flight, because a well-behaved host never does this. The stimulus injects such a strobe partway through some reads, aimed at a neighbouring address with an inverted byte. A later read of that address then shows that nothing was written, and the ready count shows that no extra pulse appeared. Bus ownership at the read-to-write and write-to-read boundaries is covered by random back-to-back mixes on a small address window. A reset raised in the middle of a read checks that the controller abandons the access.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_SETUP,
    S_RD_WAIT,
    S_RD_CAPTURE,
    S_WR_SETUP,
    S_WR_PULSE,
    S_WR_RECOVER
  } ctlState_t;

  // Strobes from the sequencer to the datapath.
  // Pin fields describe the state being entered; event fields the current one.
  typedef struct packed {
    logic latchReq;
    logic capture;
    logic respond;
    logic ceOn;
    logic oeOn;
    logic weOn;
    logic driveOn;
  } ctlStrobe_t;

  // Round a nanosecond limit up to whole clock cycles.
  function automatic int unsigned nsToCycles(input int unsigned ns,
                                             input int unsigned periodNs);
    if (ns == 0) return 0;
    return (ns + periodNs - 1) / periodNs;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ACC_CYC = 2,
  parameter int WP_CYC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output ctlStrobe_t strb
);

  localparam int MAXC  = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  ctlState_t        state, stateNext;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:       if (reqValid) stateNext = reqWrite ? S_WR_SETUP : S_RD_SETUP;
      S_RD_SETUP:   stateNext = S_RD_WAIT;
      S_RD_WAIT:    if (waitCnt == '0) stateNext = S_RD_CAPTURE;
      S_RD_CAPTURE: stateNext = S_IDLE;
      S_WR_SETUP:   stateNext = S_WR_PULSE;
      S_WR_PULSE:   if (waitCnt == '0) stateNext = S_WR_RECOVER;
      S_WR_RECOVER: stateNext = S_IDLE;
      default:      stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (stateNext == S_RD_WAIT && state != S_RD_WAIT)
        waitCnt <= CNT_W'(ACC_CYC - 1);
      else if (stateNext == S_WR_PULSE && state != S_WR_PULSE)
        waitCnt <= CNT_W'(WP_CYC - 1);
      else if (waitCnt != '0)
        waitCnt <= waitCnt - 1'b1;
    end
  end

  always_comb begin
    strb.latchReq = (state == S_IDLE) && reqValid;
    strb.capture  = (state == S_RD_CAPTURE);
    strb.respond  = (state == S_RD_CAPTURE) || (state == S_WR_RECOVER);
    strb.ceOn     = (stateNext == S_RD_SETUP) || (stateNext == S_RD_WAIT) ||
                    (stateNext == S_RD_CAPTURE) || (stateNext == S_WR_SETUP) ||
                    (stateNext == S_WR_PULSE);
    strb.oeOn     = (stateNext == S_RD_WAIT) || (stateNext == S_RD_CAPTURE);
    strb.weOn     = (stateNext == S_WR_PULSE);
    strb.driveOn  = (stateNext == S_WR_PULSE) || (stateNext == S_WR_RECOVER);
  end

  // A request is only taken from idle; any access returns to idle.
  AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqValid) |=> (state == S_RD_SETUP || state == S_WR_SETUP)); // R7
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD_WAIT && reqValid) |=> (state == S_RD_WAIT || state == S_RD_CAPTURE)); // R7

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int WP_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  // Request latch: address and byte held for the whole access.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      memDout <= '0;
    end else if (strb.latchReq) begin
      memAddr <= reqAddr;
      memDout <= reqWdata;
    end
  end

  // Memory control pins come straight from flops.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCeN    <= 1'b1;
      memOeN    <= 1'b1;
      memWeN    <= 1'b1;
      memDoutEn <= 1'b0;
    end else begin
      memCeN    <= ~strb.ceOn;
      memOeN    <= ~strb.oeOn;
      memWeN    <= ~strb.weOn;
      memDoutEn <= strb.driveOn;
    end
  end

  // Read capture and completion pulse.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspRdata <= '0;
      rspReady <= 1'b0;
    end else begin
      if (strb.capture) rspRdata <= memDin;
      rspReady <= strb.respond;
    end
  end

  // Checker state: length of the current write-enable low run.
  logic [7:0] weLowCnt;
  always_ff @(posedge clk) begin
    if (!rstN)              weLowCnt <= '0;
    else if (memWeN)        weLowCnt <= '0;
    else if (weLowCnt != 8'hFF) weLowCnt <= weLowCnt + 8'd1;
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R4
  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R4
  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDoutEn); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> memOeN); // R5
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> !memDoutEn); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr)); // R6
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |=> !rspReady); // R7
  AST_READY_IN_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> (memCeN && memOeN && memWeN && !memDoutEn)); // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == 8'(WP_CYC))); // R8

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_ACCESS_NS   = 8,
  parameter int T_WE_PULSE_NS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspReady,
  output logic [DATA_W-1:0] rspRdata,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  // Nanosecond limits rounded up to cycles, at least one each (R8).
  localparam int ACC_RAW = int'(nsToCycles(T_ACCESS_NS, CLK_PERIOD_NS));
  localparam int WP_RAW  = int'(nsToCycles(T_WE_PULSE_NS, CLK_PERIOD_NS));
  localparam int ACC_CYC = (ACC_RAW < 1) ? 1 : ACC_RAW;
  localparam int WP_CYC  = (WP_RAW < 1) ? 1 : WP_RAW;

  ctlStrobe_t strb;

  sram_ctl_fsm #(
    .ACC_CYC(ACC_CYC),
    .WP_CYC (WP_CYC)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strb    (strb)
  );

  sram_ctl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WP_CYC(WP_CYC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspReady (rspReady),
    .rspRdata (rspRdata),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .memWeN   (memWeN),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .memDin   (memDin)
  );

endmodule

// File: tb/tb_async_sram_ctrl.sv
`timescale 1ns/1ps
module tb_async_sram_ctrl;

  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int PERIOD = 5;
  localparam int T_ACC  = 8;
  localparam int T_WP   = 7;

  function automatic int ceilCyc(input int ns, input int p);
    int c;
    c = (ns + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int ACC_EXP = ceilCyc(T_ACC, PERIOD);
  localparam int WP_EXP  = ceilCyc(T_WP, PERIOD);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic rspReady;
  logic [DATA_W-1:0] rspRdata;
  logic memCeN, memOeN, memWeN, memDoutEn;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memDout;
  logic [DATA_W-1:0] busIn;

  always #2.5 clk = ~clk;

  async_sram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(PERIOD),
    .T_ACCESS_NS(T_ACC), .T_WE_PULSE_NS(T_WP)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady),
    .rspRdata(rspRdata), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn), .memDin(busIn)
  );

  // Behavioural memory model and host-side expectation table.
  logic [DATA_W-1:0] ramArr [int];
  logic [DATA_W-1:0] shadow [int];
  logic [DATA_W-1:0] modelData;
  wire modelDrive = !memCeN && !memOeN && memWeN;
  wire writeEnd   = memCeN | memWeN;

  function automatic logic [DATA_W-1:0] dfltByte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @* begin
    if (ramArr.exists(int'(memAddr))) modelData = ramArr[int'(memAddr)];
    else modelData = dfltByte(memAddr);
  end

  assign busIn = memDoutEn ? memDout : (modelDrive ? modelData : 'z);

  always @(posedge writeEnd)
    if (rstN && memDoutEn) ramArr[int'(memAddr)] = memDout;

  function automatic logic [DATA_W-1:0] expRead(input logic [ADDR_W-1:0] a);
    if (shadow.exists(int'(a))) return shadow[int'(a)];
    return dfltByte(a);
  endfunction

  int checks = 0, errors = 0, readyCnt = 0, accCnt = 0;
  bit busy = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Per-cycle bus monitor.
  int weRun = 0;
  logic prevCeLow = 1'b0, prevDrive = 1'b0;
  logic [ADDR_W-1:0] prevAddr = '0;
  logic [DATA_W-1:0] prevDout = '0;
  always @(negedge clk) begin
    if (!rstN) begin
      weRun = 0; prevCeLow = 1'b0; prevDrive = 1'b0;
    end else begin
      check(!(memDoutEn && modelDrive), "R5 bus driven from both sides", memDoutEn, 0);
      if (!memWeN) check(!memCeN && memOeN, "R4 WE low needs CE low, OE high",
                         {memCeN, memOeN}, 1);
      if (!busy) check(memCeN && memOeN && memWeN && !memDoutEn, "R2 idle standby pins",
                       {memCeN, memOeN, memWeN, memDoutEn}, 4'b1110);
      if (!memCeN && prevCeLow) check(memAddr == prevAddr, "R6 address stable", memAddr, prevAddr);
      if (memDoutEn && prevDrive) check(memDout == prevDout, "R6 write byte stable", memDout, prevDout);
      if (!memWeN) weRun++;
      else if (weRun != 0) begin
        check(weRun == WP_EXP, "R8 write pulse length", weRun, WP_EXP);
        check(memDoutEn, "R4 data held after WE rises", memDoutEn, 1);
        weRun = 0;
      end
      if (rspReady) readyCnt++;
      prevCeLow = !memCeN; prevDrive = memDoutEn;
      prevAddr = memAddr; prevDout = memDout;
    end
  end

  task automatic doAccess(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input bit intrude);
    int lat;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; busy = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ADDR_W'($urandom); reqWdata = DATA_W'($urandom);
    lat = 1;
    while (!rspReady && lat < 60) begin
      if (intrude && lat == 2) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a ^ 17'h1; reqWdata = ~d;
      end else reqValid = 1'b0;
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    accCnt++;
    if (wr) begin
      check(lat == WP_EXP + 3, "R8 write latency", lat, WP_EXP + 3);
      shadow[int'(a)] = d;
    end else begin
      check(lat == ACC_EXP + 3, "R8 read latency", lat, ACC_EXP + 3);
      check(rspRdata == expRead(a), "R3 read data", rspRdata, expRead(a));
    end
    busy = 1'b0;
    @(negedge clk);
    check(!rspReady, "R7 ready one cycle wide", rspReady, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    busy = 1'b1;
    repeat (3) @(negedge clk);
    check(memCeN && memOeN && memWeN && !memDoutEn && !rspReady, "R1 pins in reset",
          {memCeN, memOeN, memWeN, memDoutEn, rspReady}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    check(memCeN && memOeN && memWeN && !memDoutEn && !rspReady, "R1 pins after reset",
          {memCeN, memOeN, memWeN, memDoutEn, rspReady}, 5'b11100);
    busy = 1'b0;

    // Directed corners: unwritten read, extreme addresses, write/read back to back.
    doAccess(1'b0, 17'h00010, 8'h00, 1'b0);
    doAccess(1'b1, 17'h00000, 8'hC3, 1'b0);
    doAccess(1'b1, 17'h1FFFF, 8'h3C, 1'b0);
    doAccess(1'b0, 17'h00000, 8'h00, 1'b0);
    doAccess(1'b0, 17'h1FFFF, 8'h00, 1'b0);
    doAccess(1'b1, 17'h00005, 8'hFF, 1'b0);
    doAccess(1'b0, 17'h00005, 8'h00, 1'b0);

    // Ignored request during a read (R7): neighbour must keep its old byte.
    doAccess(1'b1, 17'h00021, 8'h77, 1'b0);
    doAccess(1'b0, 17'h00020, 8'h18, 1'b1);
    doAccess(1'b0, 17'h00021, 8'h00, 1'b0);
    check(readyCnt == accCnt, "R7 one ready per request", readyCnt, accCnt);

    // Reset in the middle of a read abandons it (R1).
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 17'h00040; busy = 1'b1;
    @(negedge clk); reqValid = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(memCeN && memOeN && memWeN && !memDoutEn && !rspReady, "R1 reset aborts access",
          {memCeN, memOeN, memWeN, memDoutEn, rspReady}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    busy = 1'b0;
    readyCnt = 0; accCnt = 0;

    // Constrained random mix on a small window plus occasional full-range addresses.
    for (int i = 0; i < 400; i++) begin
      bit wr;
      logic [ADDR_W-1:0] a;
      wr = 1'($urandom_range(0, 1));
      a  = ($urandom_range(0, 3) == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom_range(0, 31));
      doAccess(wr, a, DATA_W'($urandom), ($urandom_range(0, 9) == 0) && !wr);
    end
    check(readyCnt == accCnt, "R7 ready count after random run", readyCnt, accCnt);
    finishRun();
  end

endmodule